// File: doc/BRIEF.md
# Windowed Service Watchdog

This block checks that a supervised processor services it at a reasonable pace. Servicing is a falling edge on `serviceIn`. Each edge must land inside a window. The upper bound of the window is a cycle count given on `slowLimit`. The lower bound is that count divided by a ratio of 8, 16 or 64, chosen by two strap inputs. One strap code turns the checker off.

An edge that comes too soon raises a fast fault. If the count reaches the upper bound with no edge, the block raises a slow fault. Either fault is sent as a one-cycle request to a separate reset generator. That generator returns its reset-active status on `resetActive`. While that status is high, the timer is held at zero and all service activity is ignored. Counting starts again when the status drops.

The service and strap inputs come from outside the clock domain. Each passes through two synchronizing flops before edge or change detection.

Top module: `window_watchdog`

## Requirements
- R1: While `rst_n` is low, `faultPulse` is 0 and `faultCause` is 2'b00.
- R2: The strap code {strap0, strap1} selects the fast limit as `slowLimit` divided by the ratio. The codes are 2'b00 for ratio 8, 2'b01 for ratio 16 and 2'b11 for ratio 64. The division drops the remainder.
- R3: Strap code 2'b10 disables the block. No fault is produced and the timer stays at zero.
- R4: After `resetActive` is sampled low, the timer counts one per rising edge, so it holds k+1 after the (k+1)-th such edge. If no valid service edge arrives, `faultPulse` rises after the (`slowLimit`+1)-th edge with cause 2'b10 (slow). The timer then restarts from zero. A count equal to `slowLimit` is a slow fault, and it wins over a service edge judged in the same cycle.
- R5: A service edge judged at a count below the fast limit raises a fault with cause 2'b01 (fast) and clears the timer.
- R6: A service edge judged at a count from the fast limit up to `slowLimit`-1 is valid. It raises no fault and clears the timer. A count equal to the fast limit is valid.
- R7: While `resetActive` is high, the timer is held at zero, service edges are ignored and no fault is produced.
- R8: Any change of the synchronized strap code clears the timer for that cycle without a fault.
- R9: A falling service edge first sampled low at rising edge P is judged at edge P+2. It is judged against the count held after edge P+1. Any resulting fault is visible right after edge P+2.
- R10: `faultPulse` is high for exactly the cycles in which a fault is reported. `faultCause` is 2'b00 whenever `faultPulse` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resetActive | input | 1 | Reset-active status from the reset generator |
| serviceIn | input | 1 | Asynchronous service input; falling edges service the timer |
| strap0 | input | 1 | Ratio strap, upper bit of the strap code |
| strap1 | input | 1 | Ratio strap, lower bit of the strap code |
| slowLimit | input | CNT_W | Slow limit in clock cycles |
| faultPulse | output | 1 | One-cycle fault request |
| faultCause | output | 2 | Fault cause: 01 fast, 10 slow, 00 none |

## Verification
The hardest cases to reach from the ports are the exact window edges. These are an edge judged at exactly the fast limit, an edge judged one count below it, and a timeout that lands on the `slowLimit` count. Each case depends on the count at which the edge reaches the decision logic, two synchronizer stages after the pin changes.

Directed sequences release `resetActive` at a known negedge. They then drop `serviceIn` a computed number of cycles later, so the judged count is 7, 8, 3 or 4 as each case needs. Random gaps are then biased toward values near both limits. These gaps are mixed with strap changes, limit changes and short reset-active bursts, and a bench model checks them every cycle.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_FAST = 2'b01,
    CAUSE_SLOW = 2'b10
  } causeT;

  // Strobes from control to the timer datapath
  typedef struct packed {
    logic clear;
    logic advance;
  } tmrStrobeT;

  // Strap code {strap0, strap1} that turns the checker off
  localparam logic [1:0] STRAP_OFF = 2'b10;

  // Right-shift amount that turns the slow limit into the fast limit
  function automatic logic [2:0] ratioShift(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd3;
      2'b01:   return 3'd4;
      2'b11:   return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/wdw_sync.sv
module wdw_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/wdw_datapath.sv
module wdw_datapath
  import wdw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmrStrobeT        strobe,
  input  logic [CNT_W-1:0] slowLimit,
  input  logic [2:0]       ratioSh,
  output logic             atSlow,
  output logic             belowFast
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] fastLim;

  assign fastLim   = slowLimit >> ratioSh;
  assign atSlow    = (cnt >= slowLimit);
  assign belowFast = (cnt < fastLim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cnt <= '0;
    else if (strobe.clear)                 cnt <= '0;
    else if (strobe.advance && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clear |=> (cnt == '0));

  // R4
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(slowLimit) && cnt <= slowLimit) |=> (cnt <= slowLimit));

endmodule

// File: rtl/wdw_control.sv
module wdw_control
  import wdw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       resetActive,
  input  logic       svcSync,
  input  logic [1:0] strapSync,
  input  logic       atSlow,
  input  logic       belowFast,
  output tmrStrobeT  strobe,
  output logic [2:0] ratioSh,
  output logic       faultPulse,
  output logic [1:0] faultCause
);

  logic       svcPrev;
  logic [1:0] strapPrev;
  logic       fallEdge;
  logic       strapChg;
  logic       isOff;
  causeT      nextCause;
  causeT      causeQ;

  assign fallEdge = svcPrev & ~svcSync;
  assign strapChg = (strapPrev != strapSync);
  assign isOff    = (strapSync == STRAP_OFF);
  assign ratioSh  = ratioShift(strapSync);

  always_comb begin
    nextCause      = CAUSE_NONE;
    strobe.clear   = 1'b0;
    strobe.advance = 1'b0;
    if (resetActive || isOff || strapChg) begin
      strobe.clear = 1'b1;
    end else if (atSlow) begin
      strobe.clear = 1'b1;
      nextCause    = CAUSE_SLOW;
    end else if (fallEdge) begin
      strobe.clear = 1'b1;
      if (belowFast) nextCause = CAUSE_FAST;
    end else begin
      strobe.advance = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svcPrev    <= 1'b1;
      strapPrev  <= 2'b00;
      causeQ     <= CAUSE_NONE;
      faultPulse <= 1'b0;
    end else begin
      svcPrev    <= svcSync;
      strapPrev  <= strapSync;
      causeQ     <= nextCause;
      faultPulse <= (nextCause != CAUSE_NONE);
    end
  end

  assign faultCause = causeQ;

  // R10
  cause_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    faultPulse == (faultCause != 2'b00));

  // R10
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(faultCause));

  // R7
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resetActive |=> !faultPulse);

  // R3
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strapSync == STRAP_OFF) |=> !faultPulse);

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wdw_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resetActive,
  input  logic             serviceIn,
  input  logic             strap0,
  input  logic             strap1,
  input  logic [CNT_W-1:0] slowLimit,
  output logic             faultPulse,
  output logic [1:0]       faultCause
);

  logic       svcSync;
  logic [1:0] strapSync;
  tmrStrobeT  strobe;
  logic [2:0] ratioSh;
  logic       atSlow;
  logic       belowFast;

  wdw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_svcSync (
    .clk(clk), .rst_n(rst_n), .din(serviceIn), .dout(svcSync)
  );

  wdw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_strapSync (
    .clk(clk), .rst_n(rst_n), .din({strap0, strap1}), .dout(strapSync)
  );

  wdw_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .resetActive(resetActive),
    .svcSync(svcSync), .strapSync(strapSync),
    .atSlow(atSlow), .belowFast(belowFast),
    .strobe(strobe), .ratioSh(ratioSh),
    .faultPulse(faultPulse), .faultCause(faultCause)
  );

  wdw_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .slowLimit(slowLimit), .ratioSh(ratioSh),
    .atSlow(atSlow), .belowFast(belowFast)
  );

endmodule

// File: tb/window_watchdog_tb.sv
`timescale 1ns/1ps
module window_watchdog_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        resetActive = 1'b1;
  logic        serviceIn = 1'b1;
  logic        strap0 = 1'b0;
  logic        strap1 = 1'b0;
  logic [15:0] slowLimit = 16'd64;
  logic        faultPulse;
  logic [1:0]  faultCause;

  int checks = 0;
  int errors = 0;
  bit modelOn = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  window_watchdog #(.CNT_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .resetActive(resetActive),
    .serviceIn(serviceIn), .strap0(strap0), .strap1(strap1),
    .slowLimit(slowLimit), .faultPulse(faultPulse), .faultCause(faultCause)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Window ratio taken from the strap code
  function automatic int ratioOf(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b11:   return 64;
      default: return 0;
    endcase
  endfunction

  // Bench model of the window rules, advanced once per rising edge
  logic       mS1, mS2, mSP;
  logic [1:0] mT1, mT2, mTP;
  int         mAge;
  int         mExp;
  string      mTag;

  always @(posedge clk) begin
    if (!rst_n) begin
      mS1 = 1; mS2 = 1; mSP = 1;
      mT1 = 0; mT2 = 0; mTP = 0;
      mAge = 0; mExp = 0; mTag = "R1";
    end else begin
      logic fe;
      fe = mSP & ~mS2;
      mExp = 0;
      mTag = "R6";
      if (resetActive) begin
        mAge = 0; mTag = "R7";
      end else if (mT2 == 2'b10) begin
        mAge = 0; mTag = "R3";
      end else if (mTP != mT2) begin
        mAge = 0; mTag = "R8";
      end else if (mAge >= int'(slowLimit)) begin
        mExp = 4 + 2; mAge = 0; mTag = "R4";
      end else if (fe) begin
        if (mAge < int'(slowLimit) / ratioOf(mT2)) begin
          mExp = 4 + 1; mTag = "R5";
        end
        mAge = 0;
      end else begin
        mAge++;
      end
      mSP = mS2; mS2 = mS1; mS1 = serviceIn;
      mTP = mT2; mT2 = mT1; mT1 = {strap0, strap1};
    end
  end

  always @(negedge clk) begin
    if (modelOn) chk(mTag, {29'd0, faultPulse, faultCause}, mExp);
  end

  // Hold resetActive long enough for the synchronizers to settle, then
  // release it at a negedge.
  task automatic holdAndRelease();
    resetActive = 1'b1;
    serviceIn   = 1'b1;
    repeat (6) @(negedge clk);
    resetActive = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd20240611);

    // R1: state held in reset
    repeat (4) @(negedge clk);
    chk("R1", faultPulse, 0);
    chk("R1", faultCause, 0);
    rst_n = 1'b1;
    @(negedge clk);
    modelOn = 1'b1;

    // R4 and R10: timeout after exactly slowLimit+1 edges
    holdAndRelease();
    for (int k = 1; k <= 64; k++) begin
      @(negedge clk);
      chk("R4", faultPulse, 0);
    end
    @(negedge clk);
    chk("R4", faultPulse, 1);
    chk("R4", faultCause, 2);
    @(negedge clk);
    chk("R10", faultPulse, 0);
    chk("R10", faultCause, 0);

    // R6: edge judged at count 8 with fast limit 8 is valid
    holdAndRelease();
    repeat (6) @(negedge clk);
    serviceIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6", faultPulse, 0);
    @(negedge clk);
    chk("R6", faultPulse, 0);
    serviceIn = 1'b1;

    // R5 and R9: edge judged at count 7, fault visible after edge P+2
    holdAndRelease();
    repeat (5) @(negedge clk);
    serviceIn = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", faultPulse, 0);
    @(negedge clk);
    chk("R5", faultPulse, 1);
    chk("R5", faultCause, 1);
    serviceIn = 1'b1;

    // R2: ratio 16 gives fast limit 4; count 3 faults, count 4 passes
    strap0 = 1'b0; strap1 = 1'b1;
    holdAndRelease();
    @(negedge clk);
    serviceIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2", faultPulse, 1);
    chk("R2", faultCause, 1);
    serviceIn = 1'b1;
    holdAndRelease();
    repeat (2) @(negedge clk);
    serviceIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2", faultPulse, 0);
    serviceIn = 1'b1;

    // R2: ratio 64 gives fast limit 1; earliest edge (count 2) is valid
    strap0 = 1'b1; strap1 = 1'b1;
    holdAndRelease();
    serviceIn = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2", faultPulse, 0);
    serviceIn = 1'b1;

    // R3: disabled code never faults
    strap0 = 1'b1; strap1 = 1'b0;
    holdAndRelease();
    for (int k = 0; k < 90; k++) begin
      serviceIn = (k % 3 != 0);
      @(negedge clk);
      chk("R3", faultPulse, 0);
    end
    serviceIn = 1'b1;

    // R7: service edges ignored while resetActive is high
    strap0 = 1'b0; strap1 = 1'b0;
    resetActive = 1'b1;
    for (int k = 0; k < 80; k++) begin
      serviceIn = k[0];
      @(negedge clk);
      chk("R7", faultPulse, 0);
    end
    serviceIn = 1'b1;
    resetActive = 1'b0;

    // Random mix, checked against the bench model each cycle (R8 etc.)
    for (int it = 0; it < 500; it++) begin
      int r;
      int gap;
      int fl;
      r = $urandom % 100;
      fl = int'(slowLimit) / 8;
      if (r < 5) begin
        strap0 = 1'($urandom);
        strap1 = 1'($urandom);
      end else if (r < 9) begin
        resetActive = 1'b1;
        repeat (1 + $urandom % 4) @(negedge clk);
        resetActive = 1'b0;
      end else if (r < 12) begin
        case ($urandom % 4)
          0: slowLimit = 16'd64;
          1: slowLimit = 16'd40;
          2: slowLimit = 16'd17;
          default: slowLimit = 16'd128;
        endcase
      end else begin
        case ($urandom % 5)
          0: gap = $urandom % 10;
          1: gap = fl + ($urandom % 5) - 2;
          2: gap = fl + $urandom % (int'(slowLimit) - fl + 1);
          3: gap = int'(slowLimit) + ($urandom % 5) - 2;
          default: gap = int'(slowLimit) + $urandom % 20;
        endcase
        if (gap < 0) gap = 0;
        repeat (gap) @(negedge clk);
        serviceIn = 1'b0;
        repeat (1 + $urandom % 3) @(negedge clk);
        serviceIn = 1'b1;
      end
    end
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule